// File: doc/BRIEF.md
# Windowless Watchdog Timer

This block is a watchdog timer with a 16-bit register interface. A bus-clock domain holds five registers at even byte addresses: control (0x0), service (0x2), reset cause (0x4), interrupt control (0x6) and miscellaneous (0x8). A slow reference clock, sampled into the bus domain, is the time base. Once enabled, the watchdog counts down a programmed number of half-second steps. Software keeps it from expiring by writing two key words to the service register, in order.

A configurable lead time before expiry, the block raises an interrupt flag that software clears by writing 1 to it. On expiry it requests either an internal chip reset or drives an active-low external reset line. The choice is made by a control bit. It also accepts a software reset command and keeps a reset-cause bit that survives the system reset. A low-power input can freeze the countdown when software has allowed that. After reset a power-down counter runs. Unless software disarms it, the counter drops the external reset line for one clock when it expires.

Top module: `wdg_top`

## Requirements
- R1: After power-on reset, control reads 0x0030, miscellaneous reads 0x0001, reset cause and interrupt control read 0x0000, `int_rst_req` and `irq` are 0 and `ext_rst_n` is 1.
- R2: With control bit 2 set, expiry occurs (F+1) half-seconds after enabling or servicing, where F is control bits 15:8 and a half-second is TICKS_HALF rising edges of `ref_clk`.
- R3: Control bit 2 (enable) can be set by a write but not cleared by one; only a reset clears it.
- R4: The countdown is reloaded only when 0x5555 and then 0xAAAA are written to the service register. Any other value between them restarts the unlock, and 0xAAAA alone does nothing.
- R5: With control bit 3 at 0, expiry raises `int_rst_req` for RST_HOLD reference ticks while `ext_rst_n` stays high.
- R6: With control bit 3 at 1, expiry drives `ext_rst_n` low for RST_HOLD reference ticks while `int_rst_req` stays low.
- R7: Writing 0 to control bit 4 raises `int_rst_req` on the next reference tick for RST_HOLD ticks. The bit always reads back as 1.
- R8: While control bit 5 holds 0, `ext_rst_n` is low.
- R9: Reset-cause bit 1 is set by a watchdog expiry, survives `rst_n`, and is cleared by `por_n` and by a software reset command.
- R10: Interrupt-control bit 14 is set when the remaining count equals the lead field (bits 7:0, nonzero). Writing 1 to bit 14 clears it. `irq` is bit 15 AND bit 14.
- R11: Control bit 0 can only be set by a write. While it and `lp_mode` are both 1, the countdown holds its value.
- R12: Miscellaneous bit 0 resets to 1, is cleared by writing 0 and cannot be set again. If it is still 1 when PDC_TICKS reference ticks have passed since reset, `ext_rst_n` goes low for exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, spares the reset cause and hold timers |
| ref_clk | input | 1 | Slow reference clock, asynchronous |
| lp_mode | input | 1 | Low-power mode indication |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| irq | output | 1 | Pre-timeout interrupt |
| int_rst_req | output | 1 | Internal reset request, active high |
| ext_rst_n | output | 1 | External reset, active low |

## Verification
Register effects are visible one clock after the write edge, so the bench reads back and checks static outputs at the next falling edge. Timed results depend on the reference phase: synchronizer delay plus up to one tick period. These are expiry (F+1 half-seconds), the pre-timeout flag, the software reset (one to two ticks), the hold lengths (RST_HOLD ticks) and the power-down pulse (PDC_TICKS ticks). They are measured in bus clocks from a recorded start cycle and compared against a window of one tick either side. The one-clock length of the power-down pulse is checked exactly at the next falling edge.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int TOUT_W = 8;
    localparam int CNT_W  = TOUT_W + 1;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_SVC  = 4'h2;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_ICTL = 4'h6;
    localparam logic [3:0] A_MISC = 4'h8;

    localparam logic [15:0] KEY_A = 16'h5555;
    localparam logic [15:0] KEY_B = 16'hAAAA;

    typedef struct packed {
        logic [TOUT_W-1:0] tout;
        logic              wda_n;
        logic              wre;
        logic              en;
        logic              susp;
        logic              armed;
        logic              ie;
        logic              ist;
        logic [TOUT_W-1:0] lead;
        logic              pdc_en;
        logic              sreq;
        logic              svc;
    } regs_t;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [15:0]       wdata,
    input  logic              pre_evt,
    input  logic              stat_tout,
    output logic [15:0]       rdata,
    output logic [TOUT_W-1:0] tout,
    output logic [TOUT_W-1:0] lead,
    output logic              wda_n,
    output logic              wre,
    output logic              en,
    output logic              susp,
    output logic              ie,
    output logic              ist,
    output logic              pdc_en,
    output logic              sreq,
    output logic              svc
);
    localparam regs_t REGS_RST = '{tout: '0, wda_n: 1'b1, wre: 1'b0, en: 1'b0,
                                   susp: 1'b0, armed: 1'b0, ie: 1'b0, ist: 1'b0,
                                   lead: '0, pdc_en: 1'b1, sreq: 1'b0, svc: 1'b0};

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.sreq = 1'b0;
        r_d.svc  = 1'b0;
        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    r_d.tout  = wdata[15:8];
                    r_d.wda_n = wdata[5];
                    r_d.wre   = wdata[3];
                    r_d.en    = r_q.en | wdata[2];
                    r_d.susp  = r_q.susp | wdata[0];
                    r_d.sreq  = ~wdata[4];
                end
                A_SVC: begin
                    r_d.svc   = r_q.armed && (wdata == KEY_B);
                    r_d.armed = (wdata == KEY_A);
                end
                A_ICTL: begin
                    r_d.ie   = wdata[15];
                    r_d.lead = wdata[7:0];
                    if (wdata[14]) r_d.ist = 1'b0;
                end
                A_MISC: r_d.pdc_en = r_q.pdc_en & wdata[0];
                default: ;
            endcase
        end
        if (pre_evt) r_d.ist = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = {r_q.tout, 2'b00, r_q.wda_n, 1'b1, r_q.wre, r_q.en, 1'b0, r_q.susp};
            A_STAT:  rdata = {14'd0, stat_tout, 1'b0};
            A_ICTL:  rdata = {r_q.ie, r_q.ist, 6'd0, r_q.lead};
            A_MISC:  rdata = {15'd0, r_q.pdc_en};
            default: rdata = 16'h0000;
        endcase
    end

    assign tout   = r_q.tout;
    assign lead   = r_q.lead;
    assign wda_n  = r_q.wda_n;
    assign wre    = r_q.wre;
    assign en     = r_q.en;
    assign susp   = r_q.susp;
    assign ie     = r_q.ie;
    assign ist    = r_q.ist;
    assign pdc_en = r_q.pdc_en;
    assign sreq   = r_q.sreq;
    assign svc    = r_q.svc;
endmodule

// File: rtl/wdg_timebase.sv
module wdg_timebase #(
    parameter int TICKS_HALF = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    input  logic run,
    input  logic restart,
    output logic tick,
    output logic half_stb
);
    localparam int PRE_W = (TICKS_HALF > 1) ? $clog2(TICKS_HALF) : 1;

    typedef struct packed {
        logic [2:0]       sync;
        logic [PRE_W-1:0] pre;
    } tb_t;

    tb_t t_d, t_q;
    logic last;

    always_comb begin
        t_d      = t_q;
        t_d.sync = {t_q.sync[1:0], ref_clk};
        tick     = t_q.sync[1] & ~t_q.sync[2];
        last     = (t_q.pre == PRE_W'(TICKS_HALF - 1));
        half_stb = run & tick & last & ~restart;
        if (restart)          t_d.pre = '0;
        else if (run && tick) t_d.pre = last ? '0 : t_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int PDC_TICKS = 262144
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              half_stb,
    input  logic              en,
    input  logic              susp,
    input  logic              lp_mode,
    input  logic [TOUT_W-1:0] tout,
    input  logic [TOUT_W-1:0] lead,
    input  logic              svc,
    input  logic              pdc_en,
    output logic              run,
    output logic              restart,
    output logic [CNT_W-1:0]  cnt,
    output logic              expire,
    output logic              pre_evt,
    output logic              pdc_pulse
);
    localparam int PDC_W = (PDC_TICKS > 1) ? $clog2(PDC_TICKS) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en_prev;
        logic [PDC_W-1:0] pdc;
        logic             pdc_done;
    } core_t;

    localparam core_t CORE_RST = '{cnt: CNT_W'(1), en_prev: 1'b0, pdc: '0, pdc_done: 1'b0};

    core_t c_d, c_q;
    logic [CNT_W-1:0] reload;

    always_comb begin
        c_d         = c_q;
        c_d.en_prev = en;
        run         = en & ~(susp & lp_mode);
        restart     = svc | (en & ~c_q.en_prev);
        reload      = {1'b0, tout} + CNT_W'(1);
        expire      = 1'b0;
        pre_evt     = 1'b0;
        pdc_pulse   = 1'b0;
        if (!en || restart) begin
            c_d.cnt = reload;
        end else if (half_stb) begin
            if (c_q.cnt == CNT_W'(1)) begin
                expire  = 1'b1;
                c_d.cnt = reload;
            end else begin
                c_d.cnt = c_q.cnt - 1'b1;
                pre_evt = ((c_q.cnt - 1'b1) == {1'b0, lead});
            end
        end
        if (tick && !c_q.pdc_done) begin
            if (c_q.pdc == PDC_W'(PDC_TICKS - 1)) begin
                c_d.pdc_done = 1'b1;
                pdc_pulse    = pdc_en;
            end else begin
                c_d.pdc = c_q.pdc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= CORE_RST;
        else        c_q <= c_d;
    end

    assign cnt = c_q.cnt;
endmodule

// File: rtl/wdg_rstgen.sv
module wdg_rstgen #(
    parameter int RST_HOLD = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick,
    input  logic expire,
    input  logic wre,
    input  logic sreq,
    input  logic pdc_pulse,
    input  logic wda_n,
    output logic int_rst_req,
    output logic ext_rst_n,
    output logic stat_tout
);
    localparam int HOLD_W = $clog2(RST_HOLD + 1);

    typedef struct packed {
        logic [HOLD_W-1:0] int_cnt;
        logic [HOLD_W-1:0] ext_cnt;
        logic              pend;
        logic              tflag;
        logic              pdc;
    } rg_t;

    rg_t g_d, g_q;

    always_comb begin
        g_d     = g_q;
        g_d.pdc = pdc_pulse;
        if (sreq) g_d.pend = 1'b1;
        if (tick) begin
            if (g_q.int_cnt != '0) g_d.int_cnt = g_q.int_cnt - 1'b1;
            if (g_q.ext_cnt != '0) g_d.ext_cnt = g_q.ext_cnt - 1'b1;
            if (g_q.pend) begin
                g_d.pend    = 1'b0;
                g_d.int_cnt = HOLD_W'(RST_HOLD);
                g_d.tflag   = 1'b0;
            end
        end
        if (expire) begin
            g_d.tflag = 1'b1;
            if (wre) g_d.ext_cnt = HOLD_W'(RST_HOLD);
            else     g_d.int_cnt = HOLD_W'(RST_HOLD);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign int_rst_req = (g_q.int_cnt != '0);
    assign ext_rst_n   = (g_q.ext_cnt == '0) & ~g_q.pdc & wda_n;
    assign stat_tout   = g_q.tflag;
endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int TICKS_HALF = 16384,
    parameter int PDC_TICKS  = 262144,
    parameter int RST_HOLD   = 4
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        ref_clk,
    input  logic        lp_mode,
    input  logic        wr_en,
    input  logic [3:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        irq,
    output logic        int_rst_req,
    output logic        ext_rst_n
);
    logic              sys_rst_n;
    logic [TOUT_W-1:0] tout, lead;
    logic              wda_n, wre, en, susp, ie, ist, pdc_en, sreq, svc;
    logic              tick, half_stb, run, restart;
    logic [CNT_W-1:0]  cnt;
    logic              expire, pre_evt, pdc_pulse, stat_tout;

    assign sys_rst_n = rst_n & por_n;

    wdg_regs u_regs (
        .clk(clk), .rst_n(sys_rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pre_evt(pre_evt), .stat_tout(stat_tout), .rdata(rdata),
        .tout(tout), .lead(lead), .wda_n(wda_n), .wre(wre), .en(en), .susp(susp),
        .ie(ie), .ist(ist), .pdc_en(pdc_en), .sreq(sreq), .svc(svc)
    );

    wdg_timebase #(.TICKS_HALF(TICKS_HALF)) u_tb (
        .clk(clk), .rst_n(sys_rst_n), .ref_clk(ref_clk), .run(run),
        .restart(restart), .tick(tick), .half_stb(half_stb)
    );

    wdg_core #(.PDC_TICKS(PDC_TICKS)) u_core (
        .clk(clk), .rst_n(sys_rst_n), .tick(tick), .half_stb(half_stb), .en(en),
        .susp(susp), .lp_mode(lp_mode), .tout(tout), .lead(lead), .svc(svc),
        .pdc_en(pdc_en), .run(run), .restart(restart), .cnt(cnt),
        .expire(expire), .pre_evt(pre_evt), .pdc_pulse(pdc_pulse)
    );

    wdg_rstgen #(.RST_HOLD(RST_HOLD)) u_rg (
        .clk(clk), .por_n(por_n), .tick(tick), .expire(expire), .wre(wre),
        .sreq(sreq), .pdc_pulse(pdc_pulse), .wda_n(wda_n),
        .int_rst_req(int_rst_req), .ext_rst_n(ext_rst_n), .stat_tout(stat_tout)
    );

    assign irq = ie & ist;
endmodule

module wdg_checker
    import wdg_pkg::*;
(
    input logic             clk,
    input logic             sys_rst_n,
    input logic             en,
    input logic             susp,
    input logic             lp_mode,
    input logic             svc,
    input logic [CNT_W-1:0] cnt,
    input logic             wr_en,
    input logic [3:0]       addr,
    input logic [15:0]      wdata,
    input logic             expire,
    input logic             wre,
    input logic             pre_evt,
    input logic             ist,
    input logic             int_rst_req,
    input logic             ext_rst_n
);
    // R3
    en_sticky_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        en |=> en);

    // R11
    susp_sticky_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        susp |=> susp);

    // R11
    lp_hold_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (en && $past(en) && susp && lp_mode && !svc) |=> $stable(cnt));

    // R4
    svc_key_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        svc |-> $past(wr_en && addr == A_SVC && wdata == KEY_B));

    // R5
    int_on_expire_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (expire && !wre) |=> int_rst_req);

    // R6
    ext_on_expire_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (expire && wre) |=> !ext_rst_n);

    // R10
    pre_sets_flag_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        pre_evt |=> ist);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
        en |-> (cnt != '0 && cnt <= CNT_W'(256)));
endmodule

bind wdg_top wdg_checker u_chk (
    .clk(clk), .sys_rst_n(sys_rst_n), .en(en), .susp(susp), .lp_mode(lp_mode),
    .svc(svc), .cnt(cnt), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .expire(expire), .wre(wre), .pre_evt(pre_evt), .ist(ist),
    .int_rst_req(int_rst_req), .ext_rst_n(ext_rst_n)
);

// File: tb/wdg_top_bench.sv
module wdg_top_bench;
    localparam int TH = 4;
    localparam int PD = 64;
    localparam int RH = 3;

    localparam logic [3:0] CTRL = 4'h0, SVC = 4'h2, STAT = 4'h4, ICTL = 4'h6, MISC = 4'h8;

    logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0, ref_clk = 1'b0, lp_mode = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic irq, int_rst_req, ext_rst_n;

    wdg_top #(.TICKS_HALF(TH), .PDC_TICKS(PD), .RST_HOLD(RH)) u_wdg_top (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .ref_clk(ref_clk), .lp_mode(lp_mode),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
        .int_rst_req(int_rst_req), .ext_rst_n(ext_rst_n)
    );

    always #4 clk = ~clk;
    initial forever #16 ref_clk = ~ref_clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_int = 0, n_ext = 0;
    always @(negedge clk) begin
        if (int_rst_req) n_int = n_int + 1;
        if (!ext_rst_n)  n_ext = n_ext + 1;
    end

    typedef struct {
        string tag;
        int    act;
        int    lo;
        int    hi;
    } item_t;

    item_t sbq[$];
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(string tag, int act, int lo, int hi);
        item_t it;
        it.tag = tag; it.act = act; it.lo = lo; it.hi = hi;
        sbq.push_back(it);
    endtask

    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            n_chk = n_chk + 1;
            if (it.act < it.lo || it.act > it.hi) begin
                n_fail = n_fail + 1;
                $display("FAIL %s: actual %0d expected %0d..%0d", it.tag, it.act, it.lo, it.hi);
            end
        end
    end

    task automatic wr(logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1 v = int'(rdata);
    endtask

    task automatic do_reset(bit full);
        @(negedge clk);
        rst_n = 1'b0;
        if (full) por_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
    endtask

    function automatic bit cond(int which);
        case (which)
            0: return int_rst_req;
            1: return !ext_rst_n;
            2: return irq;
            3: return !int_rst_req;
            default: return ext_rst_n;
        endcase
    endfunction

    task automatic wait_for(int which, int maxc);
        int n = 0;
        while (n < maxc && !cond(which)) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int v, start, s, b, e;

        // reset state
        do_reset(1);
        rd(CTRL, v); chk("R1 ctrl reset value", v, 16'h0030, 16'h0030);
        rd(MISC, v); chk("R1 misc reset value", v, 1, 1);
        rd(STAT, v); chk("R1 cause reset value", v, 0, 0);
        rd(ICTL, v); chk("R1 ictl reset value", v, 0, 0);
        chk("R1 outputs idle", {int_rst_req, irq, ext_rst_n}, 1, 1);

        // power-down counter fires when left armed
        do_reset(1);
        start = cyc;
        wait_for(1, 400);
        chk("R12 power-down pulse time", cyc - start, 240, 272);
        @(negedge clk);
        chk("R12 pulse lasts one clock", ext_rst_n, 1, 1);
        wr(MISC, 16'h0000); wr(MISC, 16'h0001);
        rd(MISC, v); chk("R12 disarm cannot be undone", v, 0, 0);

        // power-down counter disarmed
        do_reset(1);
        wr(MISC, 16'h0000);
        b = n_ext;
        repeat (320) @(negedge clk);
        chk("R12 disarmed counter stays quiet", n_ext - b, 0, 0);

        // external reset drive bit
        do_reset(1);
        wr(MISC, 16'h0000);
        wr(CTRL, 16'h0310);
        chk("R8 bit5 at 0 drives line low", ext_rst_n, 0, 0);
        wr(CTRL, 16'h0330);
        chk("R8 bit5 at 1 releases line", ext_rst_n, 1, 1);

        // internal timeout, pre-timeout, cause, software reset
        do_reset(1);
        wr(MISC, 16'h0000);
        wr(ICTL, 16'h8002);
        b = n_ext;
        wr(CTRL, 16'h0334);
        start = cyc;
        wr(CTRL, 16'h0330);
        rd(CTRL, v); chk("R3 enable not cleared by write", v & 4, 4, 4);
        wait_for(2, 200);
        chk("R10 pre-timeout flag time", cyc - start, 26, 40);
        wr(ICTL, 16'hC002);
        chk("R10 write-1 clears flag", irq, 0, 0);
        rd(ICTL, v); chk("R10 ictl readback", v, 16'h8002, 16'h8002);
        wait_for(0, 200);
        chk("R2 expiry after 4 half-seconds", cyc - start, 56, 74);
        chk("R5 external line idle", ext_rst_n, 1, 1);
        s = cyc;
        wait_for(3, 100);
        chk("R5 internal request hold", cyc - s, 7, 14);
        chk("R5 no external pulse", n_ext - b, 0, 0);
        rd(STAT, v); chk("R9 timeout cause set", v, 2, 2);
        do_reset(0);
        rd(STAT, v); chk("R9 cause survives system reset", v, 2, 2);
        rd(CTRL, v); chk("R3 enable cleared by reset", v, 16'h0030, 16'h0030);
        wr(MISC, 16'h0000);
        wr(CTRL, 16'h0320);
        start = cyc;
        rd(CTRL, v); chk("R7 bit4 reads back 1", v, 16'h0330, 16'h0330);
        wait_for(0, 50);
        chk("R7 software reset latency", cyc - start, 1, 12);
        wait_for(3, 100);
        rd(STAT, v); chk("R9 cause cleared by software reset", v, 0, 0);

        // servicing
        do_reset(1);
        wr(MISC, 16'h0000);
        wr(CTRL, 16'h0334);
        b = n_int;
        for (int i = 0; i < 5; i++) begin
            repeat (36) @(negedge clk);
            wr(SVC, 16'h5555); wr(SVC, 16'hAAAA);
        end
        chk("R4 keyed service prevents expiry", n_int - b, 0, 0);
        start = cyc;
        wr(SVC, 16'h5555); wr(SVC, 16'h1234); wr(SVC, 16'hAAAA);
        wait_for(0, 200);
        chk("R4 broken sequence does not service", cyc - start, 56, 74);
        do_reset(1);
        wr(MISC, 16'h0000);
        wr(CTRL, 16'h0334);
        repeat (20) @(negedge clk);
        wr(SVC, 16'h5555); wr(SVC, 16'hAAAA);
        start = cyc;
        repeat (10) @(negedge clk);
        wr(SVC, 16'hAAAA);
        wait_for(0, 200);
        chk("R4 lone second key ignored", cyc - start, 56, 74);

        // external timeout action
        do_reset(1);
        wr(MISC, 16'h0000);
        b = n_int;
        wr(CTRL, 16'h033C);
        start = cyc;
        wait_for(1, 200);
        chk("R6 external expiry time", cyc - start, 56, 74);
        s = cyc;
        wait_for(4, 100);
        chk("R6 external hold", cyc - s, 7, 14);
        chk("R6 no internal request", n_int - b, 0, 0);
        rd(STAT, v); chk("R9 cause set by external expiry", v, 2, 2);

        // low-power suspend
        do_reset(1);
        wr(MISC, 16'h0000);
        lp_mode = 1'b1;
        b = n_int;
        wr(CTRL, 16'h0335);
        repeat (150) @(negedge clk);
        chk("R11 count frozen in low power", n_int - b, 0, 0);
        wr(CTRL, 16'h0334);
        rd(CTRL, v); chk("R11 suspend bit write-once", v & 1, 1, 1);
        lp_mode = 1'b0;
        start = cyc;
        wait_for(0, 200);
        e = cyc - start;
        chk("R11 countdown resumes after low power", e, 56, 74);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail = n_fail + 1;
            n_chk = n_chk + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule